// File: doc/BRIEF.md
# Dual-Dataflow Multiply-Accumulate Mesh

This block is a small grid of signed integer multiply-accumulate cells, ROWS tall and COLS wide, that computes one matrix-product tile per run. A mode input picks how the tile is mapped. With the mode at 1 (sums resident), every cell owns one output sum. The cell adds products while activation columns enter from the left and weight rows enter from the top. The sums then shift down and out. With the mode at 0 (weights resident), every cell holds one weight loaded beforehand through a row-wide preload port. Activation vectors stream in from the left and partial sums ripple downward. One finished output row leaves the bottom edge per cycle.

Operands reach a cell only from its left or upper neighbour. The block delays row i and column j by i and j cycles internally, so the caller presents plain, unskewed vectors on consecutive cycles. The block also realigns the bottom-edge outputs. A run starts with a pulse on `start_i`, which carries the length and the first vector in the same cycle. Its end is marked by a single-cycle `done_o`. The cycle count depends only on the mode, the length and the grid size.

Top module: `hybrid_pe_array`

## Requirements
- R1: After a synchronous reset, `res_o`, `res_vld_o` and `done_o` are all zero, and the block is idle.
- R2: With mode 1 and length L, the block computes P = A·B for A of size ROWS×L and B of size L×COLS. In the cycle of start and the next L−1 cycles, the caller gives A[i][t] on row slot i of `act_i` and B[t][j] on column slot j of `wt_i`. Exactly ROWS result words come out on consecutive cycles, bottom row first (row ROWS−1, then ROWS−2, and so on). Column j sits at bits [j·24 +: 24].
- R3: With mode 0, the caller loads weight row r through `wld_row_i = r`, with column j at bits [j·8 +: 8]. In cycle t (0..L−1), it gives A[t][i] on row slot i of `act_i`. Output row t is P[t][j] = Σi A[t][i]·W[i][j], with all columns in the same cycle and rows in order. The first row becomes visible after clock edge ROWS+COLS−1, counting the start edge as 0.
- R4: `done_o` is high for exactly one cycle, in the cycle right after the one that shows the last valid result. While it is high, `res_vld_o` is zero.
- R5: The run length is fixed by shape alone. `done_o` becomes visible after edge L+2·ROWS+COLS−2 with mode 1, and after edge L+ROWS+COLS−1 with mode 0, where edge 0 is the start edge.
- R6: `mode_i` is taken only while idle. A change of mode clears every accumulator and every held weight, so a weight-resident run after a switch away and back yields zeros. A start in the cycle of a mode change is ignored.
- R7: While a run is in progress, `start_i`, `mode_i` and the preload port have no effect. A held start does not begin a second run, and toggling the mode does not alter the results.
- R8: Operands are 8-bit two's complement and sums are 24-bit two's complement. For example, −128·−128 accumulated 15 times gives 245760, and 127·−128 summed over 2 rows gives −32512.
- R9: Only the L feed cycles of `act_i` and `wt_i` are used. Values presented after them do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 1 = sums resident, 0 = weights resident; taken while idle |
| start_i | input | 1 | Begin a run; the first vector comes in the same cycle |
| len_i | input | LEN_W | Run length L (1 or more), taken with start |
| act_i | input | ROWS*8 | Left-edge activations, row i at [i*8 +: 8] |
| wt_i | input | COLS*8 | Top-edge weights for mode 1, column j at [j*8 +: 8] |
| wld_en_i | input | 1 | Write one row of held weights (idle only) |
| wld_row_i | input | $clog2(ROWS) | Row written by the preload |
| wld_data_i | input | COLS*8 | Preload weights, column j at [j*8 +: 8] |
| res_o | output | COLS*24 | Result word, column j at [j*24 +: 24] |
| res_vld_o | output | COLS | Per-column valid flags for `res_o` |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest state to reach from the ports is a mode change that wipes weights already held in the cells. From outside, that wipe shows up only as a later weight-resident run that returns all zeros without a fresh preload. The stimulus loads nonzero weights, switches the mode out and back with no start, and then runs a weight-resident tile that skips the preload. A second hard case is a run disturbed while busy. The stimulus holds start high past the feed, flips the mode mid-run and drives junk on the edge inputs after the feed window. It then expects the results, the done cycle and the quiet cycles after done to match an undisturbed run.

// File: rtl/hpe_pkg.sv
package hpe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } hpe_state_e;

  localparam logic MODE_WSTAT = 1'b0;
  localparam logic MODE_OSTAT = 1'b1;
endpackage

// File: rtl/hpe_delay.sv
module hpe_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (D == 0) begin : g_wire
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] stage [D];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < D; k++) stage[k] <= '0;
        end else begin
          stage[0] <= d;
          for (int k = 1; k < D; k++) stage[k] <= stage[k-1];
        end
      end
      assign q = stage[D-1];
    end
  endgenerate
endmodule

// File: rtl/hpe_cell.sv
module hpe_cell #(
  parameter int DW = 8,
  parameter int AW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 os_i,
  input  logic                 clr_i,
  input  logic                 acc_en_i,
  input  logic                 first_i,
  input  logic                 shift_i,
  input  logic                 wld_i,
  input  logic signed [DW-1:0] wdata_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [AW-1:0] sum_i,
  output logic signed [DW-1:0] a_o,
  output logic signed [DW-1:0] b_o,
  output logic signed [AW-1:0] sum_o
);
  localparam int PW = 2 * DW;

  logic signed [DW-1:0] w_q;
  logic signed [DW-1:0] b_sel;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_x;
  logic signed [AW-1:0] base;

  // operand mux: streamed weight when sums stay put, held weight otherwise
  assign b_sel  = os_i ? b_i : w_q;
  assign prod   = a_i * b_sel;
  assign prod_x = {{(AW-PW){prod[PW-1]}}, prod};
  assign base   = os_i ? (first_i ? '0 : sum_o) : sum_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      w_q <= '0;
    end else if (wld_i) begin
      w_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_o <= '0;
      b_o <= '0;
    end else begin
      a_o <= a_i;
      b_o <= b_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sum_o <= '0;
    end else if (os_i) begin
      if (shift_i)       sum_o <= sum_i;
      else if (acc_en_i) sum_o <= base + prod_x;
    end else begin
      sum_o <= base + prod_x;
    end
  end
endmodule

// File: rtl/hpe_ctrl.sv
module hpe_ctrl
  import hpe_pkg::*;
#(
  parameter int ROWS  = 2,
  parameter int COLS  = 2,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             wld_en_i,
  output logic             mode_q,
  output logic             clr_o,
  output logic             feed_o,
  output logic             first_o,
  output logic             acc_en_o,
  output logic             shift_o,
  output logic             wld_o,
  output logic             vld_d_o,
  output logic             done_o
);
  localparam int CW = LEN_W + $clog2(ROWS + COLS) + 1;
  localparam logic [CW-1:0] OS_ADD  = CW'(ROWS + COLS - 3);
  localparam logic [CW-1:0] WS_ADD  = CW'(ROWS + COLS - 2);
  localparam logic [CW-1:0] V_FIRST = CW'(ROWS + COLS - 1);
  localparam logic [CW-1:0] D_LAST  = CW'(ROWS - 1);

  hpe_state_e      st;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   len_q;
  logic [CW-1:0]   run_last;
  logic            idle, swap, go;

  assign idle     = (st == ST_IDLE);
  assign swap     = idle && (mode_i != mode_q);
  assign go       = idle && start_i && !swap;
  assign run_last = len_q + (mode_q ? OS_ADD : WS_ADD);

  assign clr_o    = swap;
  assign wld_o    = idle && wld_en_i && !swap;
  assign feed_o   = go || ((st == ST_RUN) && (cnt < len_q));
  assign first_o  = go;
  assign acc_en_o = go || (st == ST_RUN);
  assign shift_o  = (st == ST_DRAIN);
  assign vld_d_o  = (st == ST_DRAIN) ||
                    ((st == ST_RUN) && !mode_q && (cnt >= V_FIRST));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      len_q  <= '0;
      mode_q <= MODE_WSTAT;
      done_o <= 1'b0;
    end else begin
      done_o <= (st == ST_DONE);
      case (st)
        ST_IDLE: begin
          if (swap) begin
            mode_q <= mode_i;
          end else if (go) begin
            st    <= ST_RUN;
            cnt   <= CW'(1);
            len_q <= CW'(len_i);
          end
        end
        ST_RUN: begin
          if (cnt == run_last) begin
            cnt <= '0;
            st  <= mode_q ? ST_DRAIN : ST_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (cnt == D_LAST) st <= ST_DONE;
          else               cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r7_mode_hold: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> (mode_q == $past(mode_q)));
  a_r6_no_go_on_switch: assert property (@(posedge clk) disable iff (rst)
    (idle && (mode_i != mode_q)) |=> (st == ST_IDLE));
endmodule

// File: rtl/hybrid_pe_array.sv
module hybrid_pe_array #(
  parameter int ROWS  = 2,
  parameter int COLS  = 2,
  parameter int DW    = 8,
  parameter int AW    = 24,
  parameter int LEN_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mode_i,
  input  logic                      start_i,
  input  logic [LEN_W-1:0]          len_i,
  input  logic [ROWS*DW-1:0]        act_i,
  input  logic [COLS*DW-1:0]        wt_i,
  input  logic                      wld_en_i,
  input  logic [$clog2(ROWS)-1:0]   wld_row_i,
  input  logic [COLS*DW-1:0]        wld_data_i,
  output logic [COLS*AW-1:0]        res_o,
  output logic [COLS-1:0]           res_vld_o,
  output logic                      done_o
);
  logic mode_q, clr, feed, first, acc_en, shift, wld, vld_d;

  hpe_ctrl #(.ROWS(ROWS), .COLS(COLS), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .mode_i(mode_i), .start_i(start_i), .len_i(len_i),
    .wld_en_i(wld_en_i), .mode_q(mode_q), .clr_o(clr), .feed_o(feed),
    .first_o(first), .acc_en_o(acc_en), .shift_o(shift), .wld_o(wld),
    .vld_d_o(vld_d), .done_o(done_o)
  );

  logic signed [DW-1:0] a_h [ROWS][COLS+1];
  logic signed [DW-1:0] b_v [ROWS+1][COLS];
  logic signed [AW-1:0] p_v [ROWS+1][COLS];
  logic signed [AW-1:0] dsk [COLS];
  logic        [AW-1:0] res_q [COLS];
  logic                 vld_q;

  genvar i, j;
  generate
    for (i = 0; i < ROWS; i++) begin : g_rskew
      logic [DW-1:0] a_in;
      assign a_in = feed ? act_i[i*DW +: DW] : '0;
      hpe_delay #(.W(DW), .D(i)) u_askew (
        .clk(clk), .rst(rst), .d(a_in), .q(a_h[i][0])
      );
    end

    for (j = 0; j < COLS; j++) begin : g_cskew
      logic [DW-1:0] b_in;
      logic [AW-1:0] p_bot;
      assign b_in     = (feed && mode_q) ? wt_i[j*DW +: DW] : '0;
      assign p_v[0][j] = '0;
      assign p_bot    = p_v[ROWS][j];
      hpe_delay #(.W(DW), .D(j)) u_bskew (
        .clk(clk), .rst(rst), .d(b_in), .q(b_v[0][j])
      );
      // realign the bottom edge so every column of one output row leaves together
      hpe_delay #(.W(AW), .D(COLS-1-j)) u_deskew (
        .clk(clk), .rst(rst), .d(p_bot), .q(dsk[j])
      );
      always_ff @(posedge clk) begin
        if (rst) res_q[j] <= '0;
        else if (vld_d) res_q[j] <= mode_q ? p_bot : dsk[j];
      end
      assign res_o[j*AW +: AW] = res_q[j];
    end

    for (i = 0; i < ROWS; i++) begin : g_row
      for (j = 0; j < COLS; j++) begin : g_col
        hpe_cell #(.DW(DW), .AW(AW)) u_cell (
          .clk(clk), .rst(rst), .os_i(mode_q), .clr_i(clr),
          .acc_en_i(acc_en), .first_i(first), .shift_i(shift),
          .wld_i(wld && (wld_row_i == ($clog2(ROWS))'(i))),
          .wdata_i(wld_data_i[j*DW +: DW]),
          .a_i(a_h[i][j]), .b_i(b_v[i][j]), .sum_i(p_v[i][j]),
          .a_o(a_h[i][j+1]), .b_o(b_v[i+1][j]), .sum_o(p_v[i+1][j])
        );
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= vld_d;
  end
  assign res_vld_o = {COLS{vld_q}};

  a_r4_done_after_data: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(res_vld_o[0]));
  a_r4_quiet_on_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (res_vld_o == '0));
  a_r2_flags_aligned: assert property (@(posedge clk) disable iff (rst)
    (res_vld_o == '0) || (res_vld_o == '1));
  a_r7_start_ignored_busy: assert property (@(posedge clk) disable iff (rst)
    (res_vld_o != '0) |-> !done_o);
endmodule

// File: tb/sim_hybrid_pe_array.sv
module sim_hybrid_pe_array;
  localparam int CLK_NS = 10;
  localparam int R = 2, C = 2, DW = 8, AW = 24, LW = 4;

  typedef struct packed {
    logic       mode;
    logic       noisy;
    logic [1:0] kind;
    logic [3:0] len;
    logic [7:0] seed;
  } case_t;

  localparam case_t TBL [8] = '{
    '{1'b1, 1'b0, 2'd0, 4'd3,  8'd5},
    '{1'b0, 1'b0, 2'd0, 4'd3,  8'd9},
    '{1'b1, 1'b0, 2'd0, 4'd1,  8'd17},
    '{1'b0, 1'b0, 2'd0, 4'd1,  8'd33},
    '{1'b1, 1'b0, 2'd1, 4'd15, 8'd0},
    '{1'b0, 1'b0, 2'd2, 4'd6,  8'd0},
    '{1'b1, 1'b1, 2'd0, 4'd5,  8'd71},
    '{1'b0, 1'b1, 2'd0, 4'd7,  8'd101}
  };

  logic clk = 1'b0;
  logic rst, mode_i, start_i, wld_en_i;
  logic [LW-1:0] len_i;
  logic [R*DW-1:0] act_i;
  logic [C*DW-1:0] wt_i, wld_data_i;
  logic [$clog2(R)-1:0] wld_row_i;
  logic [C*AW-1:0] res_o;
  logic [C-1:0] res_vld_o;
  logic done_o;

  int n_chk = 0, n_err = 0;
  int am [16][16];
  int bm [16][16];
  int cm [16][16];

  always #(CLK_NS/2) clk = ~clk;

  hybrid_pe_array #(.ROWS(R), .COLS(C), .DW(DW), .AW(AW), .LEN_W(LW)) u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .start_i(start_i), .len_i(len_i),
    .act_i(act_i), .wt_i(wt_i), .wld_en_i(wld_en_i), .wld_row_i(wld_row_i),
    .wld_data_i(wld_data_i), .res_o(res_o), .res_vld_o(res_vld_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gen(int kind, int seed, int r, int c, bit is_b);
    if (kind == 1) return -128;
    if (kind == 2) return is_b ? -128 : 127;
    return ((seed*7 + r*13 + c*29 + r*c*3 + (is_b ? 91 : 0)) % 256) - 128;
  endfunction

  task automatic run_case(input bit m, input bit noisy, input int kind,
                          input int len, input int seed, input bit clrw);
    int nr, kd, ed, got, first_v, last_v, done_e;
    string tag;
    nr = m ? R : len;
    kd = m ? len : R;
    for (int r = 0; r < nr; r++)
      for (int k = 0; k < kd; k++) am[r][k] = gen(kind, seed, r, k, 1'b0);
    for (int k = 0; k < kd; k++)
      for (int c = 0; c < C; c++) bm[k][c] = clrw ? 0 : gen(kind, seed, k, c, 1'b1);
    for (int r = 0; r < nr; r++)
      for (int c = 0; c < C; c++) begin
        cm[r][c] = 0;
        for (int k = 0; k < kd; k++) cm[r][c] += am[r][k] * bm[k][c];
      end
    tag = (kind != 0) ? "R8" : (clrw ? "R6" : (m ? "R2/R9" : "R3/R9"));
    if (!clrw) begin
      mode_i = m;
      repeat (2) @(negedge clk);
      if (!m) begin
        for (int r = 0; r < R; r++) begin
          wld_en_i = 1'b1; wld_row_i = r[$clog2(R)-1:0];
          for (int c = 0; c < C; c++) wld_data_i[c*DW +: DW] = bm[r][c][DW-1:0];
          @(negedge clk);
        end
        wld_en_i = 1'b0;
      end
    end
    ed = m ? (len + 2*R + C - 2) : (len + R + C - 1);
    got = 0; first_v = -1; last_v = -1; done_e = -1;
    len_i = len[LW-1:0];
    for (int n = 0; n < 200; n++) begin
      if (n > 0) @(negedge clk);
      if (res_vld_o != '0) begin
        chk(res_vld_o == '1, "R2", int'(res_vld_o), (1 << C) - 1);
        if (first_v < 0) first_v = n - 1;
        last_v = n - 1;
        if (got < nr)
          for (int c = 0; c < C; c++)
            chk($signed(res_o[c*AW +: AW]) == cm[m ? (R-1-got) : got][c], tag,
                int'($signed(res_o[c*AW +: AW])), cm[m ? (R-1-got) : got][c]);
        got++;
      end
      if (done_o) begin done_e = n - 1; break; end
      start_i = (n == 0) || (noisy && n < len + 3);          // R7 held start
      mode_i  = (noisy && n >= 1 && n < 5) ? ~m : m;          // R7 mode flip
      for (int i = 0; i < R; i++)
        act_i[i*DW +: DW] = (n < len) ? (m ? am[i][n][DW-1:0] : am[n][i][DW-1:0])
                                      : 8'(8'h5A + i + n);    // R9 junk
      for (int j = 0; j < C; j++)
        wt_i[j*DW +: DW] = (n < len && m) ? bm[n][j][DW-1:0] : 8'(8'hA7 - j);
    end
    start_i = 1'b0; mode_i = m; act_i = '0; wt_i = '0;
    chk(got == nr, m ? "R2" : "R3", got, nr);
    chk(done_e == ed, "R5", done_e, ed);
    chk(done_e == last_v + 1, "R4", done_e, last_v + 1);
    if (!m) chk(first_v == R + C - 1, "R3", first_v, R + C - 1);
    for (int q = 0; q < 3; q++) begin
      @(negedge clk);
      chk(!done_o && res_vld_o == '0, noisy ? "R7" : "R4", int'(done_o), 0);
    end
  endtask

  task automatic finish_sim;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog R5 actual=running expected=finished");
    finish_sim();
  end

  initial begin
    rst = 1'b1; mode_i = 1'b0; start_i = 1'b0; len_i = '0; act_i = '0; wt_i = '0;
    wld_en_i = 1'b0; wld_row_i = '0; wld_data_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(res_o == '0, "R1", int'(res_o[AW-1:0]), 0);
    chk(res_vld_o == '0, "R1", int'(res_vld_o), 0);
    chk(done_o == 1'b0, "R1", int'(done_o), 0);

    foreach (TBL[t])
      run_case(TBL[t].mode, TBL[t].noisy, int'(TBL[t].kind), int'(TBL[t].len),
               int'(TBL[t].seed), 1'b0);

    // R6: weights wiped by switching away and back
    mode_i = 1'b0;
    repeat (2) @(negedge clk);
    for (int r = 0; r < R; r++) begin
      wld_en_i = 1'b1; wld_row_i = r[$clog2(R)-1:0]; wld_data_i = {C{8'sd3}};
      @(negedge clk);
    end
    wld_en_i = 1'b0;
    mode_i = 1'b1; repeat (2) @(negedge clk);
    mode_i = 1'b0; repeat (2) @(negedge clk);
    run_case(1'b0, 1'b0, 0, 2, 44, 1'b1);

    // R6: start in the cycle of a mode change is ignored
    mode_i = 1'b1; start_i = 1'b1; len_i = 4'd2;
    @(negedge clk);
    start_i = 1'b0;
    for (int q = 0; q < 12; q++) begin
      @(negedge clk);
      chk(res_vld_o == '0 && !done_o, "R6", int'(res_vld_o), 0);
    end
    run_case(1'b1, 1'b0, 0, 4, 200, 1'b0);

    finish_sim();
  end
endmodule